// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block controls 32 general-purpose pins through a small word-addressed register port. Each pin is either an output, which drives a bit held in the output data register, or an input. Inputs pass through a two-flop synchronizer and are then captured in a pad level register. Software sets the direction one pin at a time. A read of the data offset returns, for each bit, either the stored output value or the sampled pad level, depending on the pin's direction.

Every input pin can latch an interrupt status bit. It can do so on a low level, a high level, a rising edge or a falling edge, chosen by a two-bit code per pin. An optional per-pin any-edge enable overrides the code. A pin is evaluated when its synchronized level changes, and all pins are evaluated when software writes the direction, either mode register, the any-edge register or the status register. Status bits are cleared by writing ones. The single interrupt line is the OR of the status bits that are enabled by a mask register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `gpio_o`, `gpio_oe` and `irq_o` are 0.
- R2: `gpio_oe` equals the direction register (offset 0x04, 1 = output), and `gpio_o` equals the data register (offset 0x00) ANDed with the direction register.
- R3: A read of offset 0x00 returns the data register bits for output pins and the pad level bits for input pins. A read of offset 0x08 returns the pad level bits, with output pins forced to 0.
- R4: The two-bit mode code of pin n sits at bits 2n+1:2n of a 64-bit mode field. Offset 0x0C holds pins 0 to 15 and offset 0x10 holds pins 16 to 31. Both registers read back what was written.
- R5: Code 00 is low-level and code 01 is high-level. Each evaluation of the pin sets its status bit while the pad level equals the code's low bit.
- R6: Code 10 is rising edge and code 11 is falling edge. The status bit is set only when the synchronized level differs from the stored pad level and the new level differs from the code's low bit. A register write alone never fires an edge-mode pin.
- R7: When a pin's bit in the any-edge register (offset 0x1C) is 1, any change of its level sets its status bit, and its mode code has no effect.
- R8: Status bits of output pins (direction bit 1) are never set.
- R9: The status register (offset 0x18) is write-1-to-clear. A detection in the same cycle as the clear keeps the bit set.
- R10: `irq_o` is 1 exactly when the status register ANDed with the mask register (offset 0x14) is non-zero.
- R11: With `HAS_EDGE_SEL` = 0, offset 0x1C reads 0, and writes to it change neither the read value nor the detection behaviour.
- R12: Only word-aligned offsets 0x00 to 0x1C are decoded. Any other address reads 0, and a write to it changes no register.
- R13: A pad level change appears in the offset 0x08 read value on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data for `bus_addr`, combinational |
| pad_i | input | PINS | Asynchronous pad levels |
| gpio_o | output | PINS | Output levels |
| gpio_oe | output | PINS | Output enables |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Random rounds load a fresh direction, mode, any-edge, mask and output configuration, clear the status and then flip a random subset of pads. Some rounds flip none. The expected status is computed from the old and new levels, so these rounds separate level hits that come from a register-write evaluation from hits that come from a level change. They also separate rising from falling polarity, and any-edge override from the mode code. The unchanged rounds show that edge modes stay quiet when only registers are written. Directed cases cover clear-versus-detection priority, the three-edge pad latency, undecoded and misaligned addresses, and a second instance built without the any-edge register, which is driven with falling edges on rising-mode pins.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the interrupt-capable GPIO controller.
// Assumes word-aligned byte addresses; the word index is address bits 4:2.
package gpio_irq_pkg;

    // Register word index (byte offset / 4); the order fixes the address map.
    typedef enum logic [2:0] {
        IDX_DATA   = 3'd0,
        IDX_DIR    = 3'd1,
        IDX_PAD    = 3'd2,
        IDX_MODE_L = 3'd3,
        IDX_MODE_H = 3'd4,
        IDX_MASK   = 3'd5,
        IDX_STAT   = 3'd6,
        IDX_ANYEDG = 3'd7
    } reg_idx_e;

    // Per-pin detection code: bit 1 = edge mode, bit 0 = polarity.
    typedef enum logic [1:0] {
        MODE_LOW  = 2'b00,
        MODE_HIGH = 2'b01,
        MODE_RISE = 2'b10,
        MODE_FALL = 2'b11
    } irq_mode_e;

    localparam int unsigned IDX_LSB = 2;
    localparam int unsigned IDX_W   = 3;

endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for asynchronous pad levels.
// Assumes STAGES >= 1; all stages clear to 0 on reset.
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= '0;
            end
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_detect.sv
// Interrupt condition for one pin, purely combinational.
// Assumes level_prev is the stored pad level and level_now the synchronized one.
// The pin is evaluated when its level changes or when eval_all is raised.
module gpio_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic      is_input,
    input  logic      any_edge,
    input  logic      eval_all,
    input  irq_mode_e mode,
    input  logic      level_now,
    input  logic      level_prev,
    output logic      hit
);

    logic changed;
    logic evaluate;

    assign changed  = level_now ^ level_prev;
    assign evaluate = changed | eval_all;

    // Decide whether this evaluation sets the pin's status bit.
    always_comb begin
        hit = 1'b0;
        if (is_input && evaluate) begin
            if (any_edge) begin
                hit = changed;
            end else begin
                case (mode)
                    MODE_LOW:  hit = ~level_now;
                    MODE_HIGH: hit = level_now;
                    MODE_RISE: hit = changed & level_now;
                    MODE_FALL: hit = changed & ~level_now;
                    default:   hit = 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_status.sv
// Interrupt status bits with write-1-to-clear and the masked request output.
// Assumes hit_i and clr_i are single-cycle vectors; a hit beats a clear.
module gpio_status #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] hit_i,
    input  logic [PINS-1:0] clr_i,
    input  logic [PINS-1:0] mask_i,
    output logic [PINS-1:0] status_o,
    output logic            irq_o
);

    logic [PINS-1:0] isr_q;

    // Clear the written bits, then set the bits of new detections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= (isr_q & ~clr_i) | hit_i;
        end
    end

    assign status_o = isr_q;
    assign irq_o    = |(isr_q & mask_i);

    // R9: a cleared bit with no detection is gone one cycle later.
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~hit_i) != '0) |=> ((isr_q & $past(clr_i & ~hit_i)) == '0))
        else $error("a_r9_clear_drops");

    // R9: every detection is visible one cycle later, even when it is cleared in the same cycle.
    a_r9_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((isr_q & $past(hit_i)) == $past(hit_i)))
        else $error("a_r9_hit_wins");

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the interrupt-capable GPIO controller: register port, pad capture,
// per-pin detection and status. Assumes full-word accesses, with reads
// combinational on bus_addr and writes taking effect on the rising edge
// where bus_wr is high.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned PINS         = 32,
    parameter int unsigned ADDR_W       = 6,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter bit          HAS_EDGE_SEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_i,
    output logic [PINS-1:0]   gpio_o,
    output logic [PINS-1:0]   gpio_oe,
    output logic              irq_o
);

    localparam int unsigned MODE_W = 2 * PINS;
    localparam int unsigned HALF_W = MODE_W / 2;

    logic [PINS-1:0]   dr_q;
    logic [PINS-1:0]   dir_q;
    logic [MODE_W-1:0] mode_q;
    logic [PINS-1:0]   mask_q;
    logic [PINS-1:0]   anyedge_q;
    logic [PINS-1:0]   pad_q;
    logic [PINS-1:0]   pad_sync;
    logic [PINS-1:0]   hit_w;
    logic [PINS-1:0]   clr_w;
    logic [PINS-1:0]   stat_w;
    logic              addr_ok;
    logic              wr_ok;
    logic              eval_all;
    reg_idx_e          word;

    // Address decode: word-aligned offsets inside the map only.
    assign word    = reg_idx_e'(bus_addr[IDX_LSB +: IDX_W]);
    assign addr_ok = ((bus_addr >> (IDX_LSB + IDX_W)) == '0) && (bus_addr[IDX_LSB-1:0] == '0);
    assign wr_ok   = bus_wr && addr_ok;

    // Writes that trigger a re-evaluation of every pin.
    assign eval_all = wr_ok && ((word == IDX_DIR) || (word == IDX_MODE_L) ||
                                (word == IDX_MODE_H) || (word == IDX_STAT) ||
                                (HAS_EDGE_SEL && (word == IDX_ANYEDG)));

    assign clr_w = (wr_ok && (word == IDX_STAT)) ? bus_wdata : '0;

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q   <= '0;
            dir_q  <= '0;
            mode_q <= '0;
            mask_q <= '0;
        end else if (wr_ok) begin
            case (word)
                IDX_DATA:   dr_q                   <= bus_wdata;
                IDX_DIR:    dir_q                  <= bus_wdata;
                IDX_MODE_L: mode_q[HALF_W-1:0]     <= bus_wdata;
                IDX_MODE_H: mode_q[MODE_W-1:HALF_W] <= bus_wdata;
                IDX_MASK:   mask_q                 <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Optional any-edge register, or a constant zero when it is left out.
    generate
        if (HAS_EDGE_SEL) begin : g_anyedge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    anyedge_q <= '0;
                end else if (wr_ok && (word == IDX_ANYEDG)) begin
                    anyedge_q <= bus_wdata;
                end
            end
        end else begin : g_no_anyedge
            assign anyedge_q = '0;
        end
    endgenerate

    gpio_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_i),
        .sync_o  (pad_sync)
    );

    // Pad level register: the previous sample used for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_q <= '0;
        end else begin
            pad_q <= pad_sync;
        end
    end

    // One detector per pin.
    generate
        for (genvar i = 0; i < PINS; i++) begin : g_pin
            gpio_pin_detect u_det (
                .is_input   (~dir_q[i]),
                .any_edge   (anyedge_q[i]),
                .eval_all   (eval_all),
                .mode       (irq_mode_e'(mode_q[2*i +: 2])),
                .level_now  (pad_sync[i]),
                .level_prev (pad_q[i]),
                .hit        (hit_w[i])
            );
        end
    endgenerate

    gpio_status #(
        .PINS (PINS)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_w),
        .clr_i    (clr_w),
        .mask_i   (mask_q),
        .status_o (stat_w),
        .irq_o    (irq_o)
    );

    assign gpio_oe = dir_q;
    assign gpio_o  = dr_q & dir_q;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (word)
                IDX_DATA:   bus_rdata = (dr_q & dir_q) | (pad_q & ~dir_q);
                IDX_DIR:    bus_rdata = dir_q;
                IDX_PAD:    bus_rdata = pad_q & ~dir_q;
                IDX_MODE_L: bus_rdata = mode_q[HALF_W-1:0];
                IDX_MODE_H: bus_rdata = mode_q[MODE_W-1:HALF_W];
                IDX_MASK:   bus_rdata = mask_q;
                IDX_STAT:   bus_rdata = stat_w;
                IDX_ANYEDG: bus_rdata = anyedge_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R2: the pin outputs move only after a write to the data or direction register.
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ok && ((word == IDX_DATA) || (word == IDX_DIR))) |=> ($stable(gpio_o) && $stable(gpio_oe)))
        else $error("a_r2_out_hold");

    // R8: a status bit can rise only for a pin that was an input.
    a_r8_input_only: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((stat_w & ~$past(stat_w) & $past(dir_q)) == '0))
        else $error("a_r8_input_only");

    // R12: an undecoded address reads zero.
    a_r12_bad_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |-> (bus_rdata == '0))
        else $error("a_r12_bad_addr_zero");

    // R10: with a zero mask the request is low.
    a_r10_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o)
        else $error("a_r10_mask_off");

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_i = '0;
    logic [31:0] gpio_o;
    logic [31:0] gpio_oe;
    logic        irq_o;

    logic [31:0] rdata_ne;
    logic [31:0] gpio_o_ne;
    logic [31:0] gpio_oe_ne;
    logic        irq_ne;

    int n_checks = 0;
    int n_err    = 0;

    localparam logic [5:0] A_DATA = 6'h00, A_DIR = 6'h04, A_PAD = 6'h08, A_ML = 6'h0C,
                           A_MH = 6'h10, A_MASK = 6'h14, A_STAT = 6'h18, A_EDGE = 6'h1C;

    always #2 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
        .gpio_o(gpio_o), .gpio_oe(gpio_oe), .irq_o(irq_o)
    );

    gpio_irq_ctrl #(.HAS_EDGE_SEL(1'b0)) dut_noedge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_ne), .pad_i(pad_i),
        .gpio_o(gpio_o_ne), .gpio_oe(gpio_oe_ne), .irq_o(irq_ne)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic [31:0] d_ne);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
        d    = bus_rdata;
        d_ne = rdata_ne;
    endtask

    task automatic drive_pads(input logic [31:0] v);
        @(negedge clk);
        pad_i = v;
        repeat (4) @(negedge clk);
    endtask

    // Expected status after a clear (all-pin evaluation at the old levels) and one pad change.
    function automatic logic [31:0] exp_status(input logic [31:0] old_p, input logic [31:0] new_p,
                                               input logic [31:0] dir, input logic [63:0] mode,
                                               input logic [31:0] anyedge);
        logic [31:0] e;
        e = '0;
        for (int i = 0; i < 32; i++) begin
            if (!dir[i]) begin
                if (anyedge[i])
                    e[i] = old_p[i] != new_p[i];
                else if (mode[2*i+1])
                    e[i] = (old_p[i] != new_p[i]) && (new_p[i] != mode[2*i]);
                else
                    e[i] = (old_p[i] == mode[2*i]) || (new_p[i] == mode[2*i]);
            end
        end
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v, vn, pads;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int k = 0; k < 8; k++) begin
            rd(6'(k * 4), v, vn);
            check("R1 register after reset", v, 32'h0);
            check("R1 register after reset (no any-edge build)", vn, 32'h0);
        end
        check("R1 gpio_oe", gpio_oe, 32'h0);
        check("R1 gpio_o", gpio_o, 32'h0);
        check("R1 irq_o", {31'h0, irq_o}, 32'h0);

        // R13 pad capture latency: visible after the third rising edge
        @(negedge clk);
        bus_addr = A_PAD;
        pad_i = 32'h0000_00F0;
        @(negedge clk); #1 check("R13 pad after 1 edge", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R13 pad after 2 edges", bus_rdata, 32'h0);
        @(negedge clk); #1 check("R13 pad after 3 edges", bus_rdata, 32'h0000_00F0);
        pads = 32'h0000_00F0;

        // R12 undecoded and misaligned writes have no effect
        wr(A_DIR, 32'hFFFF_FFFF);
        wr(A_DATA, 32'h1234_5678);
        wr(6'h21, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h05, 32'h0);
        rd(A_DATA, v, vn); check("R12 data after stray writes", v, 32'h1234_5678);
        rd(A_DIR, v, vn);  check("R12 dir after stray writes", v, 32'hFFFF_FFFF);
        rd(6'h20, v, vn);  check("R12 read 0x20", v, 32'h0);
        rd(6'h05, v, vn);  check("R12 read 0x05", v, 32'h0);
        rd(6'h3C, v, vn);  check("R12 read 0x3C", v, 32'h0);
        check("R2 gpio_o all outputs", gpio_o, 32'h1234_5678);

        // R2 / R3 mixed direction
        wr(A_DIR, 32'h0000_FF0F);
        check("R2 gpio_oe", gpio_oe, 32'h0000_FF0F);
        check("R2 gpio_o", gpio_o, 32'h0000_5608);
        rd(A_DATA, v, vn); check("R3 data mix", v, 32'h0000_56F8);
        rd(A_PAD, v, vn);  check("R3 pad masked", v, 32'h0000_00F0);

        // R6 / R9 / R10 directed: pin0 high level, pin1 rising, others falling
        wr(A_DIR, 32'h0);
        wr(A_MH, 32'hFFFF_FFFF);
        wr(A_ML, 32'hFFFF_FFF9);
        drive_pads(32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v, vn); check("R6 no edge from writes", v, 32'h0);
        drive_pads(32'h0000_0001);
        drive_pads(32'h0000_0003);
        rd(A_STAT, v, vn); check("R5 R6 high level and rising", v, 32'h0000_0003);
        wr(A_STAT, 32'h0000_0003);
        rd(A_STAT, v, vn); check("R9 clear vs level hit", v, 32'h0000_0001);
        wr(A_MASK, 32'h0000_0002);
        check("R10 irq masked off", {31'h0, irq_o}, 32'h0);
        wr(A_MASK, 32'h0000_0001);
        check("R10 irq enabled", {31'h0, irq_o}, 32'h1);
        drive_pads(32'h0000_0103);
        rd(A_STAT, v, vn); check("R6 falling mode ignores rise", v, 32'h0000_0001);
        drive_pads(32'h0000_0003);
        rd(A_STAT, v, vn); check("R6 falling edge", v, 32'h0000_0101);
        pads = 32'h0000_0003;

        // R7 / R11 any-edge override present and absent
        wr(A_ML, 32'hAAAA_AAAA);
        wr(A_MH, 32'hAAAA_AAAA);
        drive_pads(32'hFFFF_FFFF);
        wr(A_EDGE, 32'hFFFF_FFFF);
        rd(A_EDGE, v, vn);
        check("R7 any-edge readback", v, 32'hFFFF_FFFF);
        check("R11 any-edge absent reads 0", vn, 32'h0);
        wr(A_STAT, 32'hFFFF_FFFF);
        drive_pads(32'h0);
        rd(A_STAT, v, vn);
        check("R7 any-edge falling on rising code", v, 32'hFFFF_FFFF);
        check("R11 absent any-edge keeps rising code", vn, 32'h0);
        pads = 32'h0;

        // Random rounds: R3 R4 R5 R6 R7 R8 R9 R10 R2
        for (int it = 0; it < 48; it++) begin
            logic [31:0] r_dr, r_dir, r_ml, r_mh, r_es, r_mask, new_p, e;
            r_dr   = $urandom;
            r_dir  = $urandom & $urandom;
            r_ml   = $urandom;
            r_mh   = $urandom;
            r_es   = $urandom & $urandom & $urandom;
            r_mask = $urandom;
            wr(A_DATA, r_dr);
            wr(A_DIR, r_dir);
            wr(A_ML, r_ml);
            wr(A_MH, r_mh);
            wr(A_EDGE, r_es);
            wr(A_MASK, r_mask);
            wr(A_STAT, 32'hFFFF_FFFF);
            rd(A_ML, v, vn); check("R4 mode low readback", v, r_ml);
            rd(A_MH, v, vn); check("R4 mode high readback", v, r_mh);
            new_p = (it % 4 == 0) ? pads : (pads ^ ($urandom & $urandom));
            drive_pads(new_p);
            e = exp_status(pads, new_p, r_dir, {r_mh, r_ml}, r_es);
            rd(A_STAT, v, vn); check("R5 R6 R7 R8 R9 status", v, e);
            check("R10 irq", {31'h0, irq_o}, {31'h0, |(e & r_mask)});
            rd(A_DATA, v, vn); check("R3 data read", v, (r_dr & r_dir) | (new_p & ~r_dir));
            rd(A_PAD, v, vn);  check("R3 pad read", v, new_p & ~r_dir);
            check("R2 gpio_o", gpio_o, r_dr & r_dir);
            check("R2 gpio_oe", gpio_oe, r_dir);
            pads = new_p;
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule